// File: doc/BRIEF.md
# Priority Transmit Mailbox Arbiter

This block owns a small set of transmit mailboxes and decides which of them feeds the next frame to a frame-level CAN transmitter. Software uses a single write port to load each mailbox. The mode word carries an operating mode and a 4-bit priority. The remaining words hold the identifier and the two data words. A control word with a trigger bit then requests transmission and latches the length code and the remote-frame flag at the same time.

When the transmitter reports that it is idle, the arbiter looks at every mailbox that is in transmit mode and has a request pending. It takes the one with the smallest priority value. When priorities are equal, it takes the lowest index. It presents that frame until the transmitter returns a completion pulse. A successful completion marks the mailbox ready. A failed completion marks it ready and aborted. A global abort input cancels every pending request at once. Each mailbox drives its own interrupt line, and that line follows its ready flag under a per-mailbox enable.

Top module: `can_txmb_arbiter`

## Requirements
- R1: After reset every mailbox is in the disabled mode (mode field value 0) with ready=1, abort=0 and nothing pending, and tx_valid is 0.
- R2: A control write (cfg_sel=4) with bit 23 set, sent to a mailbox in transmit mode (mode word bits 26:24 = 3) that has no request pending, makes the request pending. Ready clears on the next cycle. Bits 19:16 of that write are latched as the length code and bit 20 as the remote flag.
- R3: A trigger write to a mailbox whose mode is not transmit is ignored: ready stays 1 and no frame is presented.
- R4: When the transmitter is idle, the pending transmit-mode mailbox with the smallest priority value is selected. The priority is taken from mode word bits 19:16, where 0 is the highest and 15 the lowest. tx_valid rises one cycle after the selection.
- R5: Among pending mailboxes with equal priority, the lowest index is selected first.
- R6: While tx_valid is high, tx_mb does not change until tx_done or abort_all arrives, even if a higher-priority request is made in the meantime.
- R7: tx_done with tx_ok=1 sets ready=1 and abort=0 on the presented mailbox and drops tx_valid on the next cycle.
- R8: tx_done with tx_ok=0 sets both ready=1 and abort=1 on the presented mailbox.
- R9: abort_all clears every pending request, sets abort=1 and ready=1 on each mailbox that was pending, leaves the other mailboxes' flags unchanged, and drops tx_valid.
- R10: An identifier write (cfg_sel=1) takes effect only while the mailbox is in the disabled mode and not pending. Data writes (cfg_sel=2 low word, 3 high word) are ignored while a request is pending.
- R11: irq_o bit i equals irq_en bit i AND the ready flag of mailbox i.
- R12: A pending mailbox whose mode is changed away from transmit is skipped by the arbiter. It keeps its request and becomes eligible again once it is set back to transmit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mb | input | IDX_W | Mailbox addressed by the write |
| cfg_sel | input | 3 | Word select: 0 mode, 1 identifier, 2 data low, 3 data high, 4 control |
| cfg_wdata | input | 32 | Write data |
| abort_all | input | 1 | Cancel all pending requests |
| irq_en | input | N_MB | Per-mailbox interrupt enable |
| tx_idle | input | 1 | Transmitter can accept a new frame |
| tx_done | input | 1 | Completion pulse for the presented frame |
| tx_ok | input | 1 | Completion status: 1 sent, 0 aborted |
| tx_valid | output | 1 | A frame is presented to the transmitter |
| tx_mb | output | IDX_W | Index of the presented mailbox |
| tx_id | output | ID_W | Identifier of the presented frame |
| tx_data | output | 64 | Payload of the presented frame |
| tx_len | output | 4 | Length code of the presented frame |
| tx_rtr | output | 1 | Remote-frame flag of the presented frame |
| mb_ready | output | N_MB | Per-mailbox ready flags |
| mb_abort | output | N_MB | Per-mailbox abort flags |
| irq_o | output | N_MB | Per-mailbox interrupt lines |

## Verification
A wrong priority comparison or tie-break shows up on tx_mb one cycle after tx_idle rises, so each row of the selection table checks the first and second winners directly. A request flag that is lost or stuck appears as a ready bit that fails to fall one cycle after the trigger, or as a tx_valid that never rises or never drops. A mailbox that switches while a frame is in flight shows as a tx_mb change within a few cycles of a competing trigger. A misrouted completion or abort shows as the wrong bits in mb_ready or mb_abort on the cycle after the pulse.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;
  localparam int CFG_W     = 32;
  localparam int MODE_LSB  = 24;
  localparam int MODE_W    = 3;
  localparam int PRIO_LSB  = 16;
  localparam int TRIG_BIT  = 23;
  localparam int RTR_BIT   = 20;
  localparam int LEN_LSB   = 16;
  localparam int LEN_W     = 4;
  localparam int WORD_W    = 32;

  typedef enum logic [MODE_W-1:0] {
    MB_OFF = 3'd0,
    MB_TX  = 3'd3
  } mb_mode_e;

  typedef enum logic [2:0] {
    SEL_MODE = 3'd0,
    SEL_ID   = 3'd1,
    SEL_DLO  = 3'd2,
    SEL_DHI  = 3'd3,
    SEL_CTRL = 3'd4
  } cfg_sel_e;
endpackage

// File: rtl/txmb_slot.sv
module txmb_slot
  import can_txmb_pkg::*;
#(
  parameter int PRIO_W = 4,
  parameter int ID_W   = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [2:0]        sel_i,
  input  logic [CFG_W-1:0]  wdata_i,
  input  logic              abort_all_i,
  input  logic              done_ok_i,
  input  logic              done_fail_i,
  output logic              tx_mode_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic [ID_W-1:0]   id_o,
  output logic [2*WORD_W-1:0] data_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              rtr_o,
  output logic              pend_o,
  output logic              ready_o,
  output logic              abort_o
);
  logic [MODE_W-1:0] mode_q, mode_d;
  logic [PRIO_W-1:0] prio_q, prio_d;
  logic [ID_W-1:0]   id_q, id_d;
  logic [WORD_W-1:0] dlo_q, dlo_d, dhi_q, dhi_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              rtr_q, rtr_d;
  logic              pend_q, pend_d;
  logic              rdy_q, rdy_d;
  logic              abt_q, abt_d;
  logic              trig;

  assign trig = wr_i && (sel_i == SEL_CTRL) && wdata_i[TRIG_BIT] &&
                (mode_q == MB_TX) && !pend_q && !abort_all_i;

  always_comb begin
    mode_d = mode_q;
    prio_d = prio_q;
    id_d   = id_q;
    dlo_d  = dlo_q;
    dhi_d  = dhi_q;
    len_d  = len_q;
    rtr_d  = rtr_q;
    pend_d = pend_q;
    rdy_d  = rdy_q;
    abt_d  = abt_q;
    if (wr_i && sel_i == SEL_MODE) begin
      mode_d = wdata_i[MODE_LSB +: MODE_W];
      prio_d = wdata_i[PRIO_LSB +: PRIO_W];
    end
    if (wr_i && sel_i == SEL_ID && mode_q == MB_OFF && !pend_q)
      id_d = wdata_i[ID_W-1:0];
    if (wr_i && sel_i == SEL_DLO && !pend_q) dlo_d = wdata_i;
    if (wr_i && sel_i == SEL_DHI && !pend_q) dhi_d = wdata_i;
    if (trig) begin
      len_d  = wdata_i[LEN_LSB +: LEN_W];
      rtr_d  = wdata_i[RTR_BIT];
      pend_d = 1'b1;
      rdy_d  = 1'b0;
      abt_d  = 1'b0;
    end
    if (abort_all_i && pend_q) begin
      pend_d = 1'b0;
      rdy_d  = 1'b1;
      abt_d  = 1'b1;
    end else if (done_ok_i) begin
      pend_d = 1'b0;
      rdy_d  = 1'b1;
      abt_d  = 1'b0;
    end else if (done_fail_i) begin
      pend_d = 1'b0;
      rdy_d  = 1'b1;
      abt_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MB_OFF;
      prio_q <= '0;
      id_q   <= '0;
      dlo_q  <= '0;
      dhi_q  <= '0;
      len_q  <= '0;
      rtr_q  <= 1'b0;
      pend_q <= 1'b0;
      rdy_q  <= 1'b1;
      abt_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      prio_q <= prio_d;
      id_q   <= id_d;
      dlo_q  <= dlo_d;
      dhi_q  <= dhi_d;
      len_q  <= len_d;
      rtr_q  <= rtr_d;
      pend_q <= pend_d;
      rdy_q  <= rdy_d;
      abt_q  <= abt_d;
    end
  end

  assign tx_mode_o = (mode_q == MB_TX);
  assign prio_o    = prio_q;
  assign id_o      = id_q;
  assign data_o    = {dhi_q, dlo_q};
  assign len_o     = len_q;
  assign rtr_o     = rtr_q;
  assign pend_o    = pend_q;
  assign ready_o   = rdy_q;
  assign abort_o   = abt_q;

  // R2
  pend_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !rdy_q);
  // R8
  abt_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abt_q) |-> rdy_q);
endmodule

// File: rtl/txmb_pick.sv
module txmb_pick #(
  parameter int N_MB   = 4,
  parameter int PRIO_W = 4,
  localparam int IDX_W = (N_MB > 1) ? $clog2(N_MB) : 1
) (
  input  logic [N_MB-1:0]             elig_i,
  input  logic [N_MB-1:0][PRIO_W-1:0] prio_i,
  output logic                        any_o,
  output logic [IDX_W-1:0]            idx_o
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    best  = '1;
    for (int i = N_MB - 1; i >= 0; i--) begin
      if (elig_i[i] && (!any_o || prio_i[i] <= best)) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
        best  = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/can_txmb_arbiter.sv
module can_txmb_arbiter
  import can_txmb_pkg::*;
#(
  parameter int N_MB   = 4,
  parameter int PRIO_W = 4,
  parameter int ID_W   = 30,
  localparam int IDX_W = (N_MB > 1) ? $clog2(N_MB) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_mb,
  input  logic [2:0]         cfg_sel,
  input  logic [31:0]        cfg_wdata,
  input  logic               abort_all,
  input  logic [N_MB-1:0]    irq_en,
  input  logic               tx_idle,
  input  logic               tx_done,
  input  logic               tx_ok,
  output logic               tx_valid,
  output logic [IDX_W-1:0]   tx_mb,
  output logic [ID_W-1:0]    tx_id,
  output logic [63:0]        tx_data,
  output logic [3:0]         tx_len,
  output logic               tx_rtr,
  output logic [N_MB-1:0]    mb_ready,
  output logic [N_MB-1:0]    mb_abort,
  output logic [N_MB-1:0]    irq_o
);
  logic [N_MB-1:0]             txm_v, pend_v, elig_v, ok_v, fail_v;
  logic [N_MB-1:0][PRIO_W-1:0] prio_v;
  logic [N_MB-1:0][ID_W-1:0]   id_v;
  logic [N_MB-1:0][63:0]       data_v;
  logic [N_MB-1:0][3:0]        len_v;
  logic [N_MB-1:0]             rtr_v;
  logic                        any_sel;
  logic [IDX_W-1:0]            sel_idx;
  logic                        busy_q, busy_d;
  logic [IDX_W-1:0]            cur_q, cur_d;

  for (genvar g = 0; g < N_MB; g++) begin : g_slot
    assign ok_v[g]   = busy_q && tx_done && tx_ok  && !abort_all && (cur_q == IDX_W'(g));
    assign fail_v[g] = busy_q && tx_done && !tx_ok && !abort_all && (cur_q == IDX_W'(g));
    txmb_slot #(.PRIO_W(PRIO_W), .ID_W(ID_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (cfg_we && (cfg_mb == IDX_W'(g))),
      .sel_i      (cfg_sel),
      .wdata_i    (cfg_wdata),
      .abort_all_i(abort_all),
      .done_ok_i  (ok_v[g]),
      .done_fail_i(fail_v[g]),
      .tx_mode_o  (txm_v[g]),
      .prio_o     (prio_v[g]),
      .id_o       (id_v[g]),
      .data_o     (data_v[g]),
      .len_o      (len_v[g]),
      .rtr_o      (rtr_v[g]),
      .pend_o     (pend_v[g]),
      .ready_o    (mb_ready[g]),
      .abort_o    (mb_abort[g])
    );
  end

  assign elig_v = txm_v & pend_v;

  txmb_pick #(.N_MB(N_MB), .PRIO_W(PRIO_W)) u_pick (
    .elig_i(elig_v),
    .prio_i(prio_v),
    .any_o (any_sel),
    .idx_o (sel_idx)
  );

  always_comb begin
    busy_d = busy_q;
    cur_d  = cur_q;
    if (abort_all) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      if (tx_done) busy_d = 1'b0;
    end else if (tx_idle && any_sel) begin
      busy_d = 1'b1;
      cur_d  = sel_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cur_q  <= cur_d;
    end
  end

  assign tx_valid = busy_q;
  assign tx_mb    = cur_q;
  assign tx_id    = id_v[cur_q];
  assign tx_data  = data_v[cur_q];
  assign tx_len   = len_v[cur_q];
  assign tx_rtr   = rtr_v[cur_q];
  assign irq_o    = irq_en & mb_ready;

  // R6
  hold_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_done && !abort_all) |=> (tx_valid && $stable(tx_mb)));
  // R12
  busy_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> pend_v[tx_mb]);
  // R9
  abort_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_all |=> (pend_v == '0) && !tx_valid);
  // R4
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid && tx_idle && (elig_v != '0) && !abort_all) |=> tx_valid);
endmodule

// File: tb/can_txmb_arbiter_tb_top.sv
module can_txmb_arbiter_tb_top;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we, abort_all, tx_idle, tx_done, tx_ok;
  logic [1:0] cfg_mb;
  logic [2:0] cfg_sel;
  logic [31:0] cfg_wdata;
  logic [N-1:0] irq_en;
  logic tx_valid, tx_rtr;
  logic [1:0] tx_mb;
  logic [29:0] tx_id;
  logic [63:0] tx_data;
  logic [3:0] tx_len;
  logic [N-1:0] mb_ready, mb_abort, irq_o;
  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  can_txmb_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mb(cfg_mb),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .abort_all(abort_all),
    .irq_en(irq_en), .tx_idle(tx_idle), .tx_done(tx_done), .tx_ok(tx_ok),
    .tx_valid(tx_valid), .tx_mb(tx_mb), .tx_id(tx_id), .tx_data(tx_data),
    .tx_len(tx_len), .tx_rtr(tx_rtr), .mb_ready(mb_ready),
    .mb_abort(mb_abort), .irq_o(irq_o));

  // {prio mb3..mb0, trigger mask, first winner, second winner (F = none)}
  localparam logic [27:0] VEC [6] = '{
    {16'h7925, 4'b1111, 4'd1, 4'd0},
    {16'h4444, 4'b1111, 4'd0, 4'd1},
    {16'h1133, 4'b1111, 4'd2, 4'd3},
    {16'hF0FF, 4'b1011, 4'd0, 4'd1},
    {16'h8000, 4'b1000, 4'd3, 4'hF},
    {16'h0667, 4'b0110, 4'd1, 4'd2}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int mb, input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mb = 2'(mb); cfg_sel = 3'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_mode(input int mb, input logic [2:0] mode, input logic [3:0] prio);
    wr(mb, 0, {5'b0, mode, 4'b0, prio, 16'b0});
  endtask

  task automatic trig(input int mb, input logic [3:0] len, input logic rtr);
    wr(mb, 4, {8'b0, 1'b1, 2'b0, rtr, len, 16'b0});
  endtask

  task automatic done(input logic ok);
    @(negedge clk);
    tx_done = 1'b1; tx_ok = ok;
    @(negedge clk);
    tx_done = 1'b0;
  endtask

  task automatic pulse_abort();
    @(negedge clk);
    abort_all = 1'b1;
    @(negedge clk);
    abort_all = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_mb = '0; cfg_sel = '0; cfg_wdata = '0;
    abort_all = 1'b0; irq_en = '0; tx_idle = 1'b0; tx_done = 1'b0; tx_ok = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", 64'(mb_ready), 64'hF);
    chk("R1 abort", 64'(mb_abort), 64'h0);
    chk("R1 valid", 64'(tx_valid), 64'h0);
    chk("R11 irq off", 64'(irq_o), 64'h0);
    irq_en = 4'hF;
    @(negedge clk);
    chk("R11 irq on", 64'(irq_o), 64'hF);

    // R3: trigger on a disabled mailbox is ignored
    tx_idle = 1'b1;
    trig(0, 4'd2, 1'b0);
    chk("R3 ready", 64'(mb_ready[0]), 64'h1);
    @(negedge clk);
    chk("R3 valid", 64'(tx_valid), 64'h0);
    tx_idle = 1'b0;

    // R10 / R2 / R8
    wr(0, 1, 32'h0000_0123);
    set_mode(0, 3'd3, 4'd0);
    wr(0, 1, 32'h0000_0456);
    wr(0, 2, 32'hAABB_CCDD);
    wr(0, 3, 32'h1122_3344);
    trig(0, 4'd8, 1'b1);
    chk("R2 ready low", 64'(mb_ready[0]), 64'h0);
    chk("R11 irq low", 64'(irq_o[0]), 64'h0);
    wr(0, 2, 32'h0);
    tx_idle = 1'b1;
    @(negedge clk);
    chk("R4 valid", 64'(tx_valid), 64'h1);
    chk("R4 mb", 64'(tx_mb), 64'h0);
    chk("R10 id", 64'(tx_id), 64'h123);
    chk("R10 data", tx_data, 64'h1122_3344_AABB_CCDD);
    chk("R2 len", 64'(tx_len), 64'h8);
    chk("R2 rtr", 64'(tx_rtr), 64'h1);
    done(1'b0);
    chk("R8 ready", 64'(mb_ready[0]), 64'h1);
    chk("R8 abort", 64'(mb_abort[0]), 64'h1);
    chk("R7 valid drop", 64'(tx_valid), 64'h0);
    chk("R11 irq back", 64'(irq_o[0]), 64'h1);
    tx_idle = 1'b0;

    // R6: selection held while busy
    set_mode(1, 3'd3, 4'd9);
    trig(1, 4'd1, 1'b0);
    tx_idle = 1'b1;
    @(negedge clk);
    chk("R6 first", 64'(tx_mb), 64'h1);
    trig(0, 4'd1, 1'b0);
    repeat (3) @(negedge clk);
    chk("R6 held mb", 64'(tx_mb), 64'h1);
    chk("R6 held valid", 64'(tx_valid), 64'h1);
    done(1'b1);
    @(negedge clk);
    chk("R6 next", 64'(tx_mb), 64'h0);
    chk("R6 next valid", 64'(tx_valid), 64'h1);
    done(1'b1);
    chk("R7 abort clear", 64'(mb_abort[0]), 64'h0);
    tx_idle = 1'b0;

    // R12: non-transmit mode skipped while pending
    set_mode(2, 3'd3, 4'd0);
    trig(2, 4'd3, 1'b0);
    set_mode(2, 3'd0, 4'd0);
    tx_idle = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 skipped", 64'(tx_valid), 64'h0);
    chk("R12 still pending", 64'(mb_ready[2]), 64'h0);
    set_mode(2, 3'd3, 4'd0);
    @(negedge clk);
    chk("R12 valid", 64'(tx_valid), 64'h1);
    chk("R12 mb", 64'(tx_mb), 64'h2);
    done(1'b1);
    tx_idle = 1'b0;

    // R9: global abort
    trig(0, 4'd1, 1'b0);
    trig(1, 4'd1, 1'b0);
    tx_idle = 1'b1;
    @(negedge clk);
    chk("R9 busy", 64'(tx_valid), 64'h1);
    pulse_abort();
    chk("R9 abort flags", 64'(mb_abort), 64'h3);
    chk("R9 ready flags", 64'(mb_ready), 64'hF);
    chk("R9 valid", 64'(tx_valid), 64'h0);
    @(negedge clk);
    chk("R9 stays idle", 64'(tx_valid), 64'h0);
    tx_idle = 1'b0;

    // R4 / R5 / R7 selection table
    for (int v = 0; v < 6; v++) begin
      for (int m = 0; m < N; m++) set_mode(m, 3'd3, VEC[v][12 + 4*m +: 4]);
      for (int m = 0; m < N; m++) if (VEC[v][8 + m]) trig(m, 4'd4, 1'b0);
      tx_idle = 1'b1;
      @(negedge clk);
      chk("R4 R5 first valid", 64'(tx_valid), 64'h1);
      chk("R4 R5 first mb", 64'(tx_mb), 64'(VEC[v][7:4]));
      done(1'b1);
      chk("R7 ready", 64'(mb_ready[VEC[v][5:4]]), 64'h1);
      chk("R7 abort", 64'(mb_abort[VEC[v][5:4]]), 64'h0);
      @(negedge clk);
      if (VEC[v][3:0] == 4'hF) begin
        chk("R4 none left", 64'(tx_valid), 64'h0);
      end else begin
        chk("R5 second valid", 64'(tx_valid), 64'h1);
        chk("R5 second mb", 64'(tx_mb), 64'(VEC[v][3:0]));
      end
      pulse_abort();
      chk("R9 all ready", 64'(mb_ready), 64'hF);
      tx_idle = 1'b0;
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule